// File: doc/BRIEF.md
# SDRAM Bank Precharge State Tracker

This block sits beside the command issue stage of an SDRAM controller and follows every command sent to the device, so that each of the banks always has a known state: closed, open, open with an automatic close pending, or closing. From that state it produces, one cycle ahead, whether each bank may take a row activation and whether it may take a column read or write. It also marks the exact cycle in which each bank begins to close, and flags any command that the bank states make illegal.

Closing happens in one of two ways. An explicit close command shuts one bank or all banks. A column command with the address bit A10 set requests a close once its burst ends. The automatic close waits for the row-open minimum time. It is dropped in full-page burst mode. When a column command to another bank cuts the burst short, the close is brought forward. A closing bank stays blocked for the row-precharge time.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every bank is closed: `act_ok_o` is all ones, while `rw_ok_o`, `pre_start_o` and `err_o` are zero.
- R2: `cmd_i` encodings are 0 no-op, 1 activate, 2 read, 3 write and 4 close; codes 5 to 7 act as no-op. Bit i of each vector output belongs to bank i. An activate to a closed bank opens it: in the next cycle its `rw_ok_o` bit is 1 and its `act_ok_o` bit is 0. An activate to a bank that is not closed is illegal. A read or write to a bank that is not open is illegal.
- R3: A close command with `a10_i` low shuts only bank `bank_i`. With `a10_i` high it shuts every open bank and `bank_i` is ignored. A close aimed at a bank that is already closed or closing has no effect and is legal.
- R4: The edge that starts a bank's close comes at least TRAS edges after the edge of its activate. An explicit close sooner than that is illegal. An automatic close is held back until then.
- R5: A bank whose close starts at edge E accepts an activate from edge E+TRP on. An activate before that edge is illegal.
- R6: A read with `a10_i` high starts its bank's close at edge R+BL, where R is the edge of the read.
- R7: A write with `a10_i` high starts the close at edge W+BL-1+TWR, where W is the edge of the write. When `single_wr_i` is high the write is one beat long and the close starts at W+TWR.
- R8: The close request applies to one command only. With `page_mode_i` high, or with `a10_i` low, the bank stays open after a read or write and no close starts.
- R9: A legal read or write to another bank, registered while an auto-closing read is still within its burst (edges R+1 to R+BL-1), starts the close at that same edge.
- R10: A legal read or write to another bank, registered while an auto-closing write is within its burst (edges W+1 to W+BL-1) at edge T, moves the close to edge T-1+TWR.
- R11: An illegal command raises `err_o` for the one following cycle and changes no bank state. Any command aimed at a bank with an automatic close pending is illegal.
- R12: Each `pre_start_o` bit is high for exactly one cycle, the cycle after the edge at which that bank's close starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code issued this cycle |
| bank_i | input | BA_W | Target bank of the command |
| a10_i | input | 1 | Close-all on close, auto-close on read/write |
| page_mode_i | input | 1 | Full-page burst mode; disables auto-close |
| single_wr_i | input | 1 | Writes are single-beat |
| act_ok_o | output | NUM_BANKS | Bank may take an activate next cycle |
| rw_ok_o | output | NUM_BANKS | Bank may take a read or write next cycle |
| pre_start_o | output | NUM_BANKS | One-cycle mark of a bank's close start |
| err_o | output | 1 | The previous command was illegal |

## Verification
Four properties run on every cycle. A close never starts inside the row-open window. Each close mark lasts one cycle. A bank that has just begun to close does not offer readiness. An illegal command never changes which banks are open. The exact edges of the automatic close belong to the bench's reference model, which checks them for plain and single-beat bursts, for interrupted reads and writes, and for the full-page and one-shot cases. The model also checks legality and readiness under a long mixed command stream.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPEN,
    BK_AUTOCLOSE,
    BK_CLOSING
  } bank_st_e;

endpackage

// File: rtl/sdram_trk_decode.sv
module sdram_trk_decode
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic [2:0]           cmd_i,
  input  logic [BA_W-1:0]      bank_i,
  input  logic                 a10_i,
  output logic [NUM_BANKS-1:0] sel_o,
  output logic [NUM_BANKS-1:0] close_hit_o,
  output logic                 is_act_o,
  output logic                 is_rd_o,
  output logic                 is_wr_o
);

  cmd_e cmd;
  assign cmd      = cmd_e'(cmd_i);
  assign is_act_o = (cmd == CMD_ACT);
  assign is_rd_o  = (cmd == CMD_RD);
  assign is_wr_o  = (cmd == CMD_WR);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hit
    assign sel_o[g]       = (bank_i == BA_W'(g));
    assign close_hit_o[g] = (cmd == CMD_PRE) && (a10_i || (bank_i == BA_W'(g)));
  end

endmodule

// File: rtl/sdram_trk_bank.sv
module sdram_trk_bank
  import sdram_trk_pkg::*;
#(
  parameter int TRP  = 3,
  parameter int TRAS = 6,
  parameter int TWR  = 2,
  parameter int BL   = 4,
  localparam int MAXV = (TRAS > TRP ? (TRAS > BL + TWR ? TRAS : BL + TWR)
                                    : (TRP > BL + TWR ? TRP : BL + TWR)),
  localparam int CW = $clog2(MAXV + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic close_hit_i,
  input  logic is_act_i,
  input  logic is_rd_i,
  input  logic is_wr_i,
  input  logic a10_i,
  input  logic page_mode_i,
  input  logic single_wr_i,
  input  logic cmd_ok_i,
  input  logic other_rw_i,
  output logic illegal_o,
  output logic act_ok_o,
  output logic rw_ok_o,
  output logic pre_start_o
);

  bank_st_e st_q, st_n;
  logic [CW-1:0] ras_q, ras_n, rp_q, rp_n, wait_q, wait_n, blft_q, blft_n;
  logic wr_q, wr_n;
  logic start, intr, want_act, want_rw;
  logic act_ok_q, rw_ok_q, pre_q;

  assign want_act = is_act_i && sel_i;
  assign want_rw  = (is_rd_i || is_wr_i) && sel_i;
  assign intr     = other_rw_i && (blft_q != '0);

  always_comb begin
    illegal_o = 1'b0;
    if (want_act && !(st_q == BK_IDLE || (st_q == BK_CLOSING && rp_q == '0)))
      illegal_o = 1'b1;
    if (want_rw && st_q != BK_OPEN)
      illegal_o = 1'b1;
    if (close_hit_i && ((st_q == BK_OPEN && ras_q != '0) || st_q == BK_AUTOCLOSE))
      illegal_o = 1'b1;
  end

  always_comb begin
    st_n   = st_q;
    wr_n   = wr_q;
    start  = 1'b0;
    ras_n  = (ras_q  != '0) ? ras_q  - 1'b1 : ras_q;
    rp_n   = (rp_q   != '0) ? rp_q   - 1'b1 : rp_q;
    wait_n = (wait_q != '0) ? wait_q - 1'b1 : wait_q;
    blft_n = (blft_q != '0) ? blft_q - 1'b1 : blft_q;
    unique case (st_q)
      BK_IDLE: begin
        if (want_act && cmd_ok_i) begin
          st_n  = BK_OPEN;
          ras_n = CW'(TRAS - 1);
        end
      end
      BK_OPEN: begin
        if (close_hit_i && cmd_ok_i) begin
          start = 1'b1;
        end else if (want_rw && cmd_ok_i && a10_i && !page_mode_i) begin
          st_n = BK_AUTOCLOSE;
          wr_n = is_wr_i;
          if (is_wr_i && single_wr_i) begin
            wait_n = CW'(TWR - 1);
            blft_n = '0;
          end else if (is_wr_i) begin
            wait_n = CW'(BL + TWR - 2);
            blft_n = CW'(BL - 1);
          end else begin
            wait_n = CW'(BL - 1);
            blft_n = CW'(BL - 1);
          end
        end
      end
      BK_AUTOCLOSE: begin
        if (ras_q == '0 && (wait_q == '0 || (intr && (!wr_q || TWR == 1)))) begin
          start = 1'b1;
        end else if (intr) begin
          wait_n = (wr_q && TWR >= 2) ? CW'(TWR - 2) : '0;
          blft_n = '0;
        end
      end
      BK_CLOSING: begin
        if (rp_q == '0) begin
          if (want_act && cmd_ok_i) begin
            st_n  = BK_OPEN;
            ras_n = CW'(TRAS - 1);
          end else begin
            st_n = BK_IDLE;
          end
        end
      end
      default: st_n = BK_IDLE;
    endcase
    if (start) begin
      st_n = BK_CLOSING;
      rp_n = CW'(TRP - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= BK_IDLE;
      ras_q    <= '0;
      rp_q     <= '0;
      wait_q   <= '0;
      blft_q   <= '0;
      wr_q     <= 1'b0;
      act_ok_q <= 1'b1;
      rw_ok_q  <= 1'b0;
      pre_q    <= 1'b0;
    end else begin
      st_q     <= st_n;
      ras_q    <= ras_n;
      rp_q     <= rp_n;
      wait_q   <= wait_n;
      blft_q   <= blft_n;
      wr_q     <= wr_n;
      act_ok_q <= (st_n == BK_IDLE) || (st_n == BK_CLOSING && rp_n == '0);
      rw_ok_q  <= (st_n == BK_OPEN);
      pre_q    <= start;
    end
  end

  assign act_ok_o    = act_ok_q;
  assign rw_ok_o     = rw_ok_q;
  assign pre_start_o = pre_q;

  // Independent age counter since the last accepted activate, for the lock-out check.
  logic [CW-1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
    end else if (want_act && cmd_ok_i && !illegal_o) begin
      age_q <= CW'(1);
    end else if (age_q < CW'(TRAS)) begin
      age_q <= age_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && start) begin
      assert_ras_lockout_R4: assert (age_q >= CW'(TRAS))
        else $error("close started inside the row-open window");
    end
  end

  assert_pulse_single_R12: assert property (@(posedge clk) disable iff (rst)
    pre_q |=> !pre_q);

  assert_closing_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    pre_q |-> (!rw_ok_q && (act_ok_q == (TRP == 1))));

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRP  = 3,
  parameter int TRAS = 6,
  parameter int TWR  = 2,
  parameter int BL   = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           cmd_i,
  input  logic [BA_W-1:0]      bank_i,
  input  logic                 a10_i,
  input  logic                 page_mode_i,
  input  logic                 single_wr_i,
  output logic [NUM_BANKS-1:0] act_ok_o,
  output logic [NUM_BANKS-1:0] rw_ok_o,
  output logic [NUM_BANKS-1:0] pre_start_o,
  output logic                 err_o
);

  logic [NUM_BANKS-1:0] sel, close_hit, illegal, other_rw;
  logic is_act, is_rd, is_wr, cmd_ok, err_q;

  sdram_trk_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
    .cmd_i       (cmd_i),
    .bank_i      (bank_i),
    .a10_i       (a10_i),
    .sel_o       (sel),
    .close_hit_o (close_hit),
    .is_act_o    (is_act),
    .is_rd_o     (is_rd),
    .is_wr_o     (is_wr)
  );

  assign cmd_ok = ~|illegal;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign other_rw[g] = (is_rd || is_wr) && cmd_ok && !sel[g];
    sdram_trk_bank #(.TRP(TRP), .TRAS(TRAS), .TWR(TWR), .BL(BL)) u_bank (
      .clk         (clk),
      .rst         (rst),
      .sel_i       (sel[g]),
      .close_hit_i (close_hit[g]),
      .is_act_i    (is_act),
      .is_rd_i     (is_rd),
      .is_wr_i     (is_wr),
      .a10_i       (a10_i),
      .page_mode_i (page_mode_i),
      .single_wr_i (single_wr_i),
      .cmd_ok_i    (cmd_ok),
      .other_rw_i  (other_rw[g]),
      .illegal_o   (illegal[g]),
      .act_ok_o    (act_ok_o[g]),
      .rw_ok_o     (rw_ok_o[g]),
      .pre_start_o (pre_start_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= ~cmd_ok;
  end
  assign err_o = err_q;

  assert_err_keeps_open_R11: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $stable(rw_ok_o));

endmodule

// File: tb/sdram_bank_tracker_bench.sv
module sdram_bank_tracker_bench;

  localparam int NB = 4;
  localparam int TRP = 3, TRAS = 6, TWR = 2, BL = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = 2'd0;
  logic a10 = 1'b0, pm = 1'b0, sw = 1'b0;
  logic [NB-1:0] act_ok, rw_ok, pre_start;
  logic err;

  always #10 clk = ~clk;

  sdram_bank_tracker #(.NUM_BANKS(NB), .TRP(TRP), .TRAS(TRAS), .TWR(TWR), .BL(BL))
    u_sdram_bank_tracker (
    .clk(clk), .rst(rst), .cmd_i(cmd), .bank_i(bank), .a10_i(a10),
    .page_mode_i(pm), .single_wr_i(sw), .act_ok_o(act_ok), .rw_ok_o(rw_ok),
    .pre_start_o(pre_start), .err_o(err));

  // Reference model: 0 closed, 1 open, 2 auto-close pending, 3 closing.
  int st[NB];
  longint t_act[NB], t_pre[NB], t_goal[NB], t_bend[NB];
  bit ap_wr[NB];
  longint n = 0;
  logic [NB-1:0] e_act, e_rw, e_pre;
  logic e_err;
  int vectors = 0, bad = 0;
  bit done = 0;

  task automatic model_edge(input int c, input int b, input bit x10, input bit xpm, input bit xsw);
    bit ill = 0;
    e_pre = '0;
    for (int i = 0; i < NB; i++) begin
      bit hit = (c == 4) && (x10 || b == i);
      if (hit && ((st[i] == 1 && n - t_act[i] < TRAS) || st[i] == 2)) ill = 1;
    end
    if (c == 1 && !(st[b] == 0 || (st[b] == 3 && n - t_pre[b] >= TRP))) ill = 1;
    if ((c == 2 || c == 3) && st[b] != 1) ill = 1;
    e_err = ill;
    for (int i = 0; i < NB; i++) begin
      if (st[i] == 2) begin
        if (!ill && (c == 2 || c == 3) && b != i && n <= t_bend[i]) begin
          t_goal[i] = ap_wr[i] ? n - 1 + TWR : n;
          t_bend[i] = n - 1;
        end
        if (n >= t_goal[i] && n - t_act[i] >= TRAS) begin
          st[i] = 3; t_pre[i] = n; e_pre[i] = 1;
        end
      end
    end
    if (!ill) begin
      if (c == 1) begin
        st[b] = 1; t_act[b] = n;
      end else if ((c == 2 || c == 3) && x10 && !xpm) begin
        st[b] = 2; ap_wr[b] = (c == 3);
        if (c == 2)        begin t_goal[b] = n + BL;           t_bend[b] = n + BL - 1; end
        else if (xsw)      begin t_goal[b] = n + TWR;          t_bend[b] = n;          end
        else               begin t_goal[b] = n + BL - 1 + TWR; t_bend[b] = n + BL - 1; end
      end else if (c == 4) begin
        for (int i = 0; i < NB; i++)
          if ((x10 || b == i) && st[i] == 1) begin
            st[i] = 3; t_pre[i] = n; e_pre[i] = 1;
          end
      end
    end
    for (int i = 0; i < NB; i++) begin
      e_act[i] = (st[i] == 0) || (st[i] == 3 && n + 1 - t_pre[i] >= TRP);
      e_rw[i]  = (st[i] == 1);
    end
    n++;
  endtask

  task automatic compare(input string req);
    bit miss = 0;
    vectors++;
    if (act_ok !== e_act) begin
      miss = 1; $display("FAIL %s cycle %0d act_ok %b expected %b", req, n, act_ok, e_act);
    end
    if (rw_ok !== e_rw) begin
      miss = 1; $display("FAIL %s cycle %0d rw_ok %b expected %b", req, n, rw_ok, e_rw);
    end
    if (pre_start !== e_pre) begin
      miss = 1; $display("FAIL %s cycle %0d pre_start %b expected %b", req, n, pre_start, e_pre);
    end
    if (err !== e_err) begin
      miss = 1; $display("FAIL %s cycle %0d err %b expected %b", req, n, err, e_err);
    end
    if (miss) bad++;
  endtask

  // Called at a falling edge; returns at the next falling edge after comparing.
  task automatic step(input int c, input int b, input bit x10, input string req,
                      input bit xpm = 0, input bit xsw = 0);
    cmd = 3'(c); bank = 2'(b); a10 = x10; pm = xpm; sw = xsw;
    @(posedge clk);
    model_edge(c, b, x10, xpm, xsw);
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle(input int k, input string req);
    for (int i = 0; i < k; i++) step(0, 0, 0, req);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin
      st[i] = 0; t_act[i] = -1000; t_pre[i] = -1000; t_goal[i] = 0; t_bend[i] = -1; ap_wr[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    e_act = '1; e_rw = '0; e_pre = '0; e_err = 0;
    compare("R1");
    idle(1, "R1");
    // R2: open, illegal column to closed bank, double activate
    step(1, 0, 0, "R2");
    step(2, 1, 0, "R2");
    step(1, 0, 0, "R2");
    // R4: early explicit close; R3 single close; R5 early reopen
    step(4, 0, 0, "R4");
    idle(3, "R4");
    step(4, 0, 0, "R3");
    step(1, 0, 0, "R5");
    idle(2, "R5");
    step(1, 0, 0, "R5");
    // R3: close-all with bank address ignored
    step(1, 1, 0, "R3");
    step(1, 2, 0, "R3");
    idle(6, "R3");
    step(4, 3, 1, "R3");
    step(4, 2, 0, "R3");
    idle(3, "R3");
    // R6 and R4: auto-close read late and early in the row-open window
    step(1, 0, 0, "R6"); idle(6, "R6");
    step(2, 0, 1, "R6"); idle(6, "R6");
    step(1, 0, 0, "R4");
    step(2, 0, 1, "R4"); idle(8, "R4");
    // R7: auto-close write, burst and single-beat
    step(1, 1, 0, "R7"); idle(6, "R7");
    step(3, 1, 1, "R7"); idle(8, "R7");
    step(1, 1, 0, "R7"); idle(6, "R7");
    step(3, 1, 1, "R7", 0, 1); idle(5, "R7");
    // R8: full-page mode and non-persistent request
    step(1, 2, 0, "R8"); idle(6, "R8");
    step(2, 2, 1, "R8", 1, 0);
    step(2, 2, 0, "R8"); idle(6, "R8");
    step(4, 2, 0, "R8"); idle(3, "R8");
    // R9: read interrupted by read, then by write
    step(1, 0, 0, "R9"); step(1, 1, 0, "R9"); idle(6, "R9");
    step(2, 0, 1, "R9"); step(2, 1, 0, "R9"); idle(4, "R9");
    step(1, 0, 0, "R9"); idle(6, "R9");
    step(2, 0, 1, "R9"); step(0, 0, 0, "R9"); step(3, 1, 0, "R9"); idle(4, "R9");
    // R10: write interrupted by read; R11 access to pending bank
    step(1, 0, 0, "R10"); idle(6, "R10");
    step(3, 0, 1, "R10"); step(0, 0, 0, "R10"); step(2, 1, 0, "R10"); idle(4, "R10");
    step(1, 0, 0, "R11"); idle(6, "R11");
    step(2, 0, 1, "R11"); step(3, 0, 0, "R11"); step(4, 0, 0, "R11"); idle(6, "R11");
    // R12 and mixed traffic across all rules
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 9);
      int c = (r < 3) ? 0 : (r < 5) ? 1 : (r < 7) ? 2 : (r < 8) ? 3 : 4;
      step(c, $urandom_range(0, NB - 1), $urandom_range(0, 1) == 1, "R12",
           $urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired at cycle %0d", n);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end

endmodule